// File: doc/BRIEF.md
# Complementary PWM Dead-Band and Fault Shutdown Stage

This stage sits after a PWM action generator and turns its channel levels into a pair of gate-drive signals for one half-bridge leg. In dead-band mode the high-side drive follows the reference channel and the low-side drive follows its inverse. Each drive's rising edge waits a programmable number of clock cycles, so one switch turns off before the other turns on. Falling edges are not delayed. In bypass mode the two channel levels pass straight to the two drives.

An external fault input shuts both drives off in the same cycle it is seen. The shutdown is held in a latch after the fault input drops. Software releases it with a clear strobe, and only once the fault input is low again. While the shutdown is active the dead-band counters are held at zero. When drive resumes, the first rising edge of each drive waits the full dead-band again.

Top module: `pwmdt_stage`

## Requirements
- R1: A synchronous reset clears the fault latch and both dead-band counters. After reset, with all inputs low, `fault_latched`, `drv_hi` and `drv_lo` are 0.
- R2: With `dt_en` = 0 and no fault active, `drv_hi` equals `ch_a` and `drv_lo` equals `ch_b` in the same cycle.
- R3: With `dt_en` = 1 and no fault active, the high-side target is `ch_a` and the low-side target is the inverse of `ch_a`. `ch_b` has no effect on either drive.
- R4: With `dt_en` = 1, a drive goes high exactly `dt_cycles` clock edges after its target goes high, provided the target stays high. The counter saturates at its maximum value.
- R5: With `dt_en` = 1, a drive goes low in the same cycle its target goes low.
- R6: With `dt_en` = 1 and `dt_cycles` = 0, `drv_lo` is the exact inverse of `drv_hi` and no gap cycle is added.
- R7: With `dt_en` = 1, `drv_hi` and `drv_lo` are never both high.
- R8: While `fault_in` is 1, both drives are 0 in the same cycle. `fault_latched` is 1 from the next clock edge.
- R9: Once the latch is set, both drives stay 0 and `fault_latched` stays 1 until a `fault_clr` pulse is seen with `fault_in` = 0. `fault_latched` falls at that edge.
- R10: A `fault_clr` pulse while `fault_in` is 1 is ignored, and the latch stays set.
- R11: The dead-band counters are held at zero while a fault is active. After the latch is released, a drive whose target is already high rises only after the full `dt_cycles` delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_a | input | 1 | Reference PWM level (channel A) |
| ch_b | input | 1 | Second channel level, used only in bypass mode |
| dt_en | input | 1 | 1: dead-band complementary mode, 0: bypass |
| dt_cycles | input | DT_W | Dead-band length in clock cycles |
| fault_in | input | 1 | External fault, active high |
| fault_clr | input | 1 | One-cycle strobe that releases the latched fault |
| drv_hi | output | 1 | High-side drive |
| drv_lo | output | 1 | Low-side drive |
| fault_latched | output | 1 | Fault latch state |

## Verification
Some results appear with no clock edge at all: the bypass outputs, falling edges and fault blanking are combinational, so they must show in the same cycle as the input change. Other results are edge-counted. A rising drive appears `dt_cycles` edges after its target rises, and the fault latch changes one edge after `fault_in` or a valid clear. The bench drives inputs just after each rising edge and samples at the falling edge. Its reference model updates its integer run lengths and latch bit at every rising edge from the inputs held over that edge, so each expected value lands in the cycle in which the requirement says it is due.

// File: rtl/pwmdt_pkg.sv
package pwmdt_pkg;

    // Drive legs of the half bridge
    localparam int unsigned LEG_COUNT = 2;

    typedef enum logic {
        LEG_HI = 1'b0,
        LEG_LO = 1'b1
    } leg_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } drv_pair_t;

    typedef struct packed {
        logic bypass_n;   // 1: dead-band complementary mode
        logic blank;      // fault active: force drives off, clear counters
    } stage_ctl_t;

    // Target level of a leg before shaping.
    function automatic logic leg_target(input logic dt_mode, input logic a,
                                        input logic b, input leg_e leg);
        logic t;
        if (leg == LEG_HI) t = a;
        else               t = dt_mode ? ~a : b;
        return t;
    endfunction

endpackage

// File: rtl/pwmdt_leg.sv
module pwmdt_leg #(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic            target,
    input  logic            shape_en,
    input  logic [DT_W-1:0] dt_cycles,
    output logic            drive
);
    localparam logic [DT_W-1:0] RUN_MAX = '1;

    // Length of the current high run of the target, saturating
    logic [DT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || hold || !target) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Falling edge passes at once; rising edge waits until the run is long enough
    always_comb begin
        if (shape_en) drive = target && (run_q >= dt_cycles);
        else          drive = target;
    end

endmodule

// File: rtl/pwmdt_fault.sv
module pwmdt_fault (
    input  logic clk,
    input  logic rst,
    input  logic fault_in,
    input  logic fault_clr,
    output logic active,
    output logic latched
);
    logic flt_q;

    // Set has priority: a clear during a live fault is dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            flt_q <= 1'b0;
        end else if (fault_in) begin
            flt_q <= 1'b1;
        end else if (fault_clr) begin
            flt_q <= 1'b0;
        end
    end

    assign active  = fault_in | flt_q;
    assign latched = flt_q;

endmodule

// File: rtl/pwmdt_stage.sv
module pwmdt_stage
    import pwmdt_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ch_a,
    input  logic            ch_b,
    input  logic            dt_en,
    input  logic [DT_W-1:0] dt_cycles,
    input  logic            fault_in,
    input  logic            fault_clr,
    output logic            drv_hi,
    output logic            drv_lo,
    output logic            fault_latched
);
    stage_ctl_t            ctl;
    logic                  flt_active;
    logic [LEG_COUNT-1:0]  tgt;
    logic [LEG_COUNT-1:0]  shaped;
    drv_pair_t             drv;

    pwmdt_fault u_fault (
        .clk       (clk),
        .rst       (rst),
        .fault_in  (fault_in),
        .fault_clr (fault_clr),
        .active    (flt_active),
        .latched   (fault_latched)
    );

    assign ctl.bypass_n = dt_en;
    assign ctl.blank    = flt_active;

    for (genvar g = 0; g < LEG_COUNT; g++) begin : g_leg
        assign tgt[g] = leg_target(ctl.bypass_n, ch_a, ch_b, leg_e'(g));

        pwmdt_leg #(.DT_W(DT_W)) u_leg (
            .clk       (clk),
            .rst       (rst),
            .hold      (ctl.blank),
            .target    (tgt[g]),
            .shape_en  (ctl.bypass_n),
            .dt_cycles (dt_cycles),
            .drive     (shaped[g])
        );
    end

    always_comb begin
        drv.hi = shaped[LEG_HI] & ~ctl.blank;
        drv.lo = shaped[LEG_LO] & ~ctl.blank;
    end

    assign drv_hi = drv.hi;
    assign drv_lo = drv.lo;

endmodule

// File: rtl/pwmdt_stage_chk.sv
module pwmdt_stage_chk #(
    parameter int unsigned DT_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            ch_a,
    input logic            ch_b,
    input logic            dt_en,
    input logic [DT_W-1:0] dt_cycles,
    input logic            fault_in,
    input logic            fault_clr,
    input logic            drv_hi,
    input logic            drv_lo,
    input logic            fault_latched
);
    // R2: bypass passes channels through
    a_r2_bypass_hi: assert property (@(posedge clk) disable iff (rst)
        (!dt_en && !fault_in && !fault_latched) |-> (drv_hi == ch_a));
    a_r2_bypass_lo: assert property (@(posedge clk) disable iff (rst)
        (!dt_en && !fault_in && !fault_latched) |-> (drv_lo == ch_b));

    // R7: no shoot-through in dead-band mode
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        dt_en |-> !(drv_hi && drv_lo));

    // R5: high side drops with its reference
    a_r5_fall_now: assert property (@(posedge clk) disable iff (rst)
        (dt_en && !ch_a) |-> !drv_hi);

    // R4: a delayed rise needs the reference high on the previous cycle
    a_r4_rise_after_ref: assert property (@(posedge clk) disable iff (rst)
        ($rose(drv_hi) && dt_en && $past(dt_en) && dt_cycles != '0) |-> $past(ch_a));

    // R8: fault blanks both drives and sets the latch
    a_r8_blank: assert property (@(posedge clk) disable iff (rst)
        (fault_in || fault_latched) |-> (!drv_hi && !drv_lo));
    a_r8_latch_set: assert property (@(posedge clk) disable iff (rst)
        fault_in |=> fault_latched);

    // R10: clear during a live fault is ignored
    a_r10_clear_ignored: assert property (@(posedge clk) disable iff (rst)
        (fault_in && fault_clr) |=> fault_latched);

    // R9: latch holds without a clear
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (fault_latched && !fault_clr) |=> fault_latched);
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (fault_latched && fault_clr && !fault_in) |=> !fault_latched);

endmodule

bind pwmdt_stage pwmdt_stage_chk #(.DT_W(DT_W)) u_chk (.*);

// File: tb/pwmdt_stage_test.sv
module pwmdt_stage_test;
    localparam int DT_W    = 8;
    localparam int RUN_CAP = (1 << DT_W) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ch_a = 1'b0;
    logic            ch_b = 1'b0;
    logic            dt_en = 1'b0;
    logic [DT_W-1:0] dt_cycles = '0;
    logic            fault_in = 1'b0;
    logic            fault_clr = 1'b0;
    logic            drv_hi, drv_lo, fault_latched;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string ctx = "R1";

    // 250 MHz
    always #2 clk = ~clk;

    pwmdt_stage #(.DT_W(DT_W)) uut (
        .clk(clk), .rst(rst), .ch_a(ch_a), .ch_b(ch_b), .dt_en(dt_en),
        .dt_cycles(dt_cycles), .fault_in(fault_in), .fault_clr(fault_clr),
        .drv_hi(drv_hi), .drv_lo(drv_lo), .fault_latched(fault_latched)
    );

    // Behavioural reference: high-run lengths of each target and the latch bit
    int run_hi = 0;
    int run_lo = 0;
    bit m_flt  = 1'b0;

    function automatic bit tgt_hi();
        return ch_a;
    endfunction
    function automatic bit tgt_lo();
        return dt_en ? !ch_a : ch_b;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            run_hi = 0; run_lo = 0; m_flt = 1'b0;
        end else begin
            bit blank;
            blank = fault_in || m_flt;
            run_hi = (blank || !tgt_hi()) ? 0 : ((run_hi < RUN_CAP) ? run_hi + 1 : run_hi);
            run_lo = (blank || !tgt_lo()) ? 0 : ((run_lo < RUN_CAP) ? run_lo + 1 : run_lo);
            if (fault_in)       m_flt = 1'b1;
            else if (fault_clr) m_flt = 1'b0;
        end
    end

    task automatic check1(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Compare every cycle at the falling edge
    always @(negedge clk) begin
        bit blank, e_hi, e_lo;
        string rq;
        blank = fault_in || m_flt;
        e_hi = !blank && tgt_hi() && (!dt_en || run_hi >= int'(dt_cycles));
        e_lo = !blank && tgt_lo() && (!dt_en || run_lo >= int'(dt_cycles));
        if (ctx != "")                rq = ctx;
        else if (blank)               rq = "R8";
        else if (!dt_en)              rq = "R2";
        else if (dt_cycles == 0)      rq = "R6";
        else                          rq = "R4/R5";
        check1(rq, "drv_hi", drv_hi, e_hi);
        check1((dt_en && ctx == "") ? "R3" : rq, "drv_lo", drv_lo, e_lo);
        check1(fault_in ? "R10" : "R9", "fault_latched", fault_latched, m_flt);
        if (dt_en && !rst) check1("R7", "overlap", drv_hi & drv_lo, 0);
        if (dt_en && dt_cycles == 0 && !blank && !rst)
            check1("R6", "complement", drv_lo, !drv_hi);
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Directed rise-delay measure (R4): returns edges until drv_hi is high
    task automatic measure_rise(int dt);
        int n = 0;
        ch_a = 1'b0; step(2);
        ch_a = 1'b1;
        @(negedge clk);
        while (!drv_hi && n < 400) begin
            @(posedge clk); #1; n++;
            @(negedge clk);
        end
        check1("R4", "rise delay", n, dt);
        step(1);
    endtask

    initial begin
        // R1 reset
        ctx = "R1";
        step(3);
        rst = 1'b0;
        step(1);
        check1("R1", "fault_latched after reset", fault_latched, 0);
        check1("R1", "drv_hi after reset", drv_hi, 0);
        check1("R1", "drv_lo after reset", drv_lo, 0);
        ctx = "";

        // R2 bypass
        dt_en = 1'b0;
        for (int i = 0; i < 40; i++) begin
            ch_a = $urandom_range(0, 1); ch_b = $urandom_range(0, 1); step(1);
        end

        // R3/R4/R5 dead-band with long and short pulses, ch_b noise
        dt_en = 1'b1; dt_cycles = 8'd5;
        for (int k = 0; k < 4; k++) begin
            ch_a = 1'b1;
            for (int i = 0; i < 12; i++) begin ch_b = $urandom_range(0, 1); step(1); end
            ch_a = 1'b0;
            for (int i = 0; i < 12; i++) begin ch_b = $urandom_range(0, 1); step(1); end
        end
        ch_a = 1'b1; step(3); ch_a = 1'b0; step(2); ch_a = 1'b1; step(8);
        measure_rise(5);
        dt_cycles = 8'd3;
        for (int i = 0; i < 60; i++) begin
            ch_a = $urandom_range(0, 1); ch_b = $urandom_range(0, 1); step(1);
        end
        measure_rise(3);

        // R6 zero dead-band
        dt_cycles = 8'd0;
        for (int i = 0; i < 30; i++) begin ch_a = $urandom_range(0, 1); step(1); end
        measure_rise(0);

        // R8/R9/R10/R11 fault
        dt_cycles = 8'd4; ch_a = 1'b1; step(10);
        fault_in = 1'b1;
        @(negedge clk);
        check1("R8", "hi blanked same cycle", drv_hi, 0);
        step(1);
        check1("R8", "latch set", fault_latched, 1);
        fault_clr = 1'b1; step(1); fault_clr = 1'b0;
        check1("R10", "clear ignored", fault_latched, 1);
        fault_in = 1'b0; step(5);
        check1("R9", "latch held", fault_latched, 1);
        check1("R9", "hi held low", drv_hi, 0);
        ctx = "R11";
        fault_clr = 1'b1; step(1); fault_clr = 1'b0;
        check1("R9", "latch released", fault_latched, 0);
        step(3);
        check1("R11", "hi still in dead-band", drv_hi, 0);
        step(1);
        check1("R11", "hi after full dead-band", drv_hi, 1);
        ch_a = 1'b0; step(8); ch_a = 1'b1; step(8);
        ctx = "";

        // R4 saturation at the largest count
        dt_cycles = 8'd255;
        measure_rise(255);
        step(20);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule